// File: doc/BRIEF.md
# Clock-Stop SPI Master

This block drives a serial peripheral as a bus master using a stopped-clock framing. The serial clock rests low between words. An active-low select line frames each word. Outgoing data leaves on the rising edge of the serial clock, and incoming data is taken on the falling edge. The serial clock is derived from the block's own reference clock `clk` through a programmable divider. That divider splits every serial period into a high phase and a low phase, using a rule that depends on whether the divider value is even or odd. The low-phase length sets the gap from select assertion to the first rising edge. One full serial period is held after the last falling edge before select is released.

A word is offered on a valid/ready command port. `start_valid` with `tx_word`, `word_len` and `div` is taken on a clock edge where `start_ready` is high. `start_ready` stays low for the whole transfer, so the word source is held off (back-pressured) and any command offered meanwhile is left pending and has no effect. The result port has no back-pressure. `done` pulses for one cycle when select rises, and `rx_word` then holds the received word until the next completion. The serial data output is exposed as a value plus a separate enable, so that the tri-state driver can sit in the pad ring.

Top module: `spi_cs_master`

## Requirements
- R1: The serial clock period is 1 + D reference cycles, where D = `div`, except that a `div` of 0 is used as D = 1.
- R2: For even D the high phase lasts D/2 + 1 cycles and the low phase lasts D/2 cycles. For odd D both phases last (D + 1)/2 cycles.
- R3: Out of reset and between transfers, `sclk` is 0, `cs_n` is 1, `dx_oe` is 0, `done` is 0, `rx_word` is 0 and `start_ready` is 1.
- R4: `cs_n` falls on the edge that accepts a command. The first rising edge of `sclk` comes exactly one low-phase length (L cycles) later.
- R5: `cs_n` returns high exactly one serial period (H + L cycles) after the last falling edge of `sclk`. The whole select window is therefore (n + 1)·(H + L) cycles for an n-bit word.
- R6: `dx` shows bit n-1 of `tx_word` from select assertion, and moves to the next lower bit at each later rising edge, so bit 0 is sent last. `dr` is sampled on each falling edge. `rx_word` is right-justified, with the first sampled bit at position n-1 and all bits at n and above reading 0.
- R7: `dx_oe` drops exactly L cycles after the last falling edge of `sclk`, and it is 0 whenever `cs_n` is 1.
- R8: `word_len` values below 4 are used as 4, and values above 32 are used as 32. The number of `sclk` rising edges per transfer equals the resulting n.
- R9: A command is taken only on an edge with `start_valid` and `start_ready` both high. `start_ready` is 0 from acceptance until the cycle `done` is high. A `start_valid` seen while `start_ready` is 0 changes neither the serial activity nor the received word.
- R10: `done` is high for exactly one cycle, the cycle in which `cs_n` first reads 1 again. `rx_word` is valid in that cycle and unchanged after it until the next `done`.
- R11: A `div` of 0 produces the same timing as a `div` of 1: one-cycle high phase, one-cycle low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Command offered |
| start_ready | output | 1 | Block idle; command taken when both are high |
| tx_word | input | 32 | Word to send, right-justified |
| word_len | input | 6 | Bits per word, clamped to 4..32 |
| div | input | 8 | Divider value D |
| rx_word | output | 32 | Last received word, right-justified |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low slave select |
| dx | output | 1 | Serial data out value |
| dx_oe | output | 1 | Output enable for the `dx` pad driver |
| dr | input | 1 | Serial data in |

## Verification
The completion of one word and the acceptance of the next can fall in the same cycle. `done` and `start_ready` are both high while `cs_n` rises, so a command held valid through the end of a transfer is taken on the very next edge. The bench provokes this by keeping `start_valid` asserted across a word boundary with `dr` looped back to `dx`. It changes `tx_word` in the cycle it sees `done`. It then judges that the first word is in `rx_word` during `done`, that `cs_n` is low again exactly one cycle later, and that the second word returns intact.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_HIGH = 3'd2,
    ST_LOW  = 3'd3,
    ST_TAIL = 3'd4
  } seq_st_e;
endpackage

// File: rtl/spi_cs_phase_calc.sv
// Turns a divider value into high- and low-phase lengths in reference cycles.
module spi_cs_phase_calc #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] hi_len,
  output logic [DIV_W-1:0] lo_len
);
  logic [DIV_W-1:0] d_eff;
  logic [DIV_W:0]   d_inc;

  always_comb begin
    d_eff = (div == '0) ? DIV_W'(1) : div;
    d_inc = {1'b0, d_eff} + 1'b1;
    if (d_eff[0]) begin
      hi_len = d_inc[DIV_W:1];
      lo_len = d_inc[DIV_W:1];
    end else begin
      hi_len = (d_eff >> 1) + 1'b1;
      lo_len = d_eff >> 1;
    end
  end
endmodule

// File: rtl/spi_cs_seq.sv
// Frame sequencer: select lead, bit phases, select lag, registered pin outputs.
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [DIV_W-1:0] hi_len,
  input  logic [DIV_W-1:0] lo_len,
  input  logic [LEN_W-1:0] bit_cnt,
  output logic             load,
  output logic             shift,
  output logic             sample,
  output logic             commit,
  output logic             sclk,
  output logic             cs_n,
  output logic             dx_oe,
  output logic             done
);
  seq_st_e          st, st_nx;
  logic [DIV_W-1:0] cnt, cnt_nx;
  logic [DIV_W-1:0] hi_q, hi_nx, lo_q, lo_nx;
  logic [LEN_W-1:0] left, left_nx;

  assign start_ready = (st == ST_IDLE);

  always_comb begin
    st_nx   = st;
    cnt_nx  = cnt;
    hi_nx   = hi_q;
    lo_nx   = lo_q;
    left_nx = left;
    load    = 1'b0;
    shift   = 1'b0;
    sample  = 1'b0;
    commit  = 1'b0;
    if (st == ST_IDLE) begin
      if (start_valid) begin
        st_nx   = ST_LEAD;
        cnt_nx  = lo_len - 1'b1;
        hi_nx   = hi_len;
        lo_nx   = lo_len;
        left_nx = bit_cnt - 1'b1;
        load    = 1'b1;
      end
    end else if (cnt != '0) begin
      cnt_nx = cnt - 1'b1;
    end else begin
      case (st)
        ST_LEAD: begin
          st_nx  = ST_HIGH;
          cnt_nx = hi_q - 1'b1;
        end
        ST_HIGH: begin
          st_nx  = ST_LOW;
          cnt_nx = lo_q - 1'b1;
          sample = 1'b1;
        end
        ST_LOW: begin
          cnt_nx = hi_q - 1'b1;
          if (left == '0) begin
            st_nx = ST_TAIL;
          end else begin
            st_nx   = ST_HIGH;
            shift   = 1'b1;
            left_nx = left - 1'b1;
          end
        end
        ST_TAIL: begin
          st_nx  = ST_IDLE;
          commit = 1'b1;
        end
        default: st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      hi_q  <= DIV_W'(1);
      lo_q  <= DIV_W'(1);
      left  <= '0;
      sclk  <= 1'b0;
      cs_n  <= 1'b1;
      dx_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      st    <= st_nx;
      cnt   <= cnt_nx;
      hi_q  <= hi_nx;
      lo_q  <= lo_nx;
      left  <= left_nx;
      sclk  <= (st_nx == ST_HIGH);
      cs_n  <= (st_nx == ST_IDLE);
      dx_oe <= (st_nx == ST_LEAD) || (st_nx == ST_HIGH) || (st_nx == ST_LOW);
      done  <= commit;
    end
  end
endmodule

// File: rtl/spi_cs_shifter.sv
// Transmit and receive shift registers plus the held result word.
module spi_cs_shifter #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                shift,
  input  logic                sample,
  input  logic                commit,
  input  logic [LEN_W-1:0]    bit_cnt,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic                dr,
  output logic                tx_msb,
  output logic [MAX_BITS-1:0] rx_word
);
  logic [MAX_BITS-1:0] tx_sh, rx_sh;
  logic [LEN_W-1:0]    align;

  assign align  = LEN_W'(MAX_BITS) - bit_cnt;
  assign tx_msb = tx_sh[MAX_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
    end else begin
      if (load) begin
        tx_sh <= tx_word << align;
        rx_sh <= '0;
      end else begin
        if (shift)  tx_sh <= {tx_sh[MAX_BITS-2:0], 1'b0};
        if (sample) rx_sh <= {rx_sh[MAX_BITS-2:0], dr};
      end
      if (commit) rx_word <= rx_sh;
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int MAX_BITS = 32,
  parameter int MIN_BITS = 4,
  parameter int DIV_W    = 8,
  localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                start_valid,
  output logic                start_ready,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [LEN_W-1:0]    word_len,
  input  logic [DIV_W-1:0]    div,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                done,
  output logic                sclk,
  output logic                cs_n,
  output logic                dx,
  output logic                dx_oe,
  input  logic                dr,
  input  logic                clk,
  input  logic                rst_n
);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_BITS);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_BITS);

  logic [LEN_W-1:0] bit_cnt;
  logic [DIV_W-1:0] hi_len, lo_len;
  logic             load, shift, sample, commit, tx_msb;

  always_comb begin
    if (word_len < LEN_LO)      bit_cnt = LEN_LO;
    else if (word_len > LEN_HI) bit_cnt = LEN_HI;
    else                        bit_cnt = word_len;
  end

  spi_cs_phase_calc #(.DIV_W(DIV_W)) u_phase (
    .div    (div),
    .hi_len (hi_len),
    .lo_len (lo_len)
  );

  spi_cs_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .hi_len      (hi_len),
    .lo_len      (lo_len),
    .bit_cnt     (bit_cnt),
    .load        (load),
    .shift       (shift),
    .sample      (sample),
    .commit      (commit),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .dx_oe       (dx_oe),
    .done        (done)
  );

  spi_cs_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .shift   (shift),
    .sample  (sample),
    .commit  (commit),
    .bit_cnt (bit_cnt),
    .tx_word (tx_word),
    .dr      (dr),
    .tx_msb  (tx_msb),
    .rx_word (rx_word)
  );

  assign dx = dx_oe & tx_msb;
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start_valid,
  input logic start_ready,
  input logic sclk,
  input logic cs_n,
  input logic dx_oe,
  input logic done
);
  // R3: serial clock rests low while deselected
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R4: a rising clock edge only happens inside an open select window
  p_rise_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !$past(cs_n));
  // R7: pad driver off whenever deselected
  p_tristate_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dx_oe);
  // R7: driver turns off only during a low clock phase
  p_oe_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dx_oe) |-> !sclk);
  // R9: busy blocks further commands
  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !start_ready);
  // R9: an accepted command opens the select window next cycle
  p_accept_selects_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !cs_n);
  // R10: completion pulse lasts one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: completion coincides with select release
  p_done_on_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n)));
endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .sclk        (sclk),
  .cs_n        (cs_n),
  .dx_oe       (dx_oe),
  .done        (done)
);

// File: tb/test_spi_cs_master.sv
module test_spi_cs_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] tx_word = '0;
  logic [5:0]  word_len = 6'd8;
  logic [7:0]  div = 8'd1;
  logic [31:0] rx_word;
  logic        done, sclk, cs_n, dx, dx_oe;
  logic        dr_drv = 1'b0;
  logic        loop_en = 1'b0;
  logic        dr;
  int          vectors = 0;
  int          misses = 0;
  int          cycles = 0;

  assign dr = loop_en ? dx : dr_drv;

  always #2 clk = ~clk;

  spi_cs_master i_spi_cs_master (
    .start_valid (start_valid),
    .start_ready (start_ready),
    .tx_word     (tx_word),
    .word_len    (word_len),
    .div         (div),
    .rx_word     (rx_word),
    .done        (done),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .dx          (dx),
    .dx_oe       (dx_oe),
    .dr          (dr),
    .clk         (clk),
    .rst_n       (rst_n)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R3", "cs_n idle", 64'(cs_n), 64'd1);
    chk("R3", "sclk idle", 64'(sclk), 64'd0);
    chk("R3", "dx_oe idle", 64'(dx_oe), 64'd0);
    chk("R3", "done idle", 64'(done), 64'd0);
    chk("R3", "rx_word reset", 64'(rx_word), 64'd0);
    chk("R3", "ready idle", 64'(start_ready), 64'd1);
  endtask

  // One transfer, with the bench acting as the slave. poke offers a second command while busy.
  task automatic t_xfer(input string tag, input int dv, input int ln,
                        input logic [31:0] tx, input logic [31:0] sl, input bit poke);
    int d, hh, ll, tt, n, t, rises, falls, bad_r, bad_f, oe_fall, cs_hi, done_t, done_cnt;
    logic [31:0] mask, got;
    logic prev_s, prev_oe;
    d  = (dv == 0) ? 1 : dv;
    hh = (d % 2 == 0) ? d / 2 + 1 : (d + 1) / 2;
    ll = (d % 2 == 0) ? d / 2 : (d + 1) / 2;
    tt = hh + ll;
    n  = (ln < 4) ? 4 : ((ln > 32) ? 32 : ln);
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    got = '0; rises = 0; falls = 0; bad_r = 0; bad_f = 0;
    oe_fall = -1; cs_hi = -1; done_t = -1; done_cnt = 0;
    prev_s = 1'b0; prev_oe = 1'b1;
    loop_en = 1'b0;
    @(negedge clk);
    div = 8'(dv); word_len = 6'(ln); tx_word = tx; start_valid = 1'b1;
    chk("R9", {tag, " ready before accept"}, 64'(start_ready), 64'd1);
    @(negedge clk);
    start_valid = 1'b0;
    t = 0;
    while (t < 4000) begin
      if (poke && t == 2) begin
        chk("R9", {tag, " ready while busy"}, 64'(start_ready), 64'd0);
        start_valid = 1'b1; tx_word = ~tx; word_len = 6'd5;
      end
      if (poke && t == 3) start_valid = 1'b0;
      if (sclk && !prev_s) begin
        if (t != ll + rises * tt) bad_r++;
        got = {got[30:0], dx};
        if (rises < n) dr_drv = sl[n - 1 - rises];
        rises++;
      end
      if (!sclk && prev_s) begin
        if (t != ll + falls * tt + hh) bad_f++;
        falls++;
      end
      if (!dx_oe && prev_oe && oe_fall < 0) oe_fall = t;
      if (done) begin done_cnt++; done_t = t; end
      if (cs_n) begin cs_hi = t; break; end
      prev_s = sclk; prev_oe = dx_oe;
      @(negedge clk);
      t++;
    end
    chk("R1 R2 R4 R11", {tag, " rising edge times"}, 64'(bad_r), 64'd0);
    chk("R1 R2 R11", {tag, " falling edge times"}, 64'(bad_f), 64'd0);
    chk("R8", {tag, " clock count"}, 64'(rises), 64'(n));
    chk("R5", {tag, " select window"}, 64'(cs_hi), 64'((n + 1) * tt));
    chk("R7", {tag, " driver off time"}, 64'(oe_fall), 64'(ll + n * tt));
    chk("R6", {tag, " dx bits msb first"}, 64'(got), 64'(tx & mask));
    chk("R6", {tag, " rx word"}, 64'(rx_word), 64'(sl & mask));
    chk("R10", {tag, " done at release"}, 64'(done_t), 64'(cs_hi));
    @(negedge clk);
    chk("R10", {tag, " done single"}, 64'(done), 64'd0);
    chk("R10", {tag, " rx held"}, 64'(rx_word), 64'(sl & mask));
    chk("R3", {tag, " idle after"}, {61'd0, sclk, dx_oe, cs_n}, 64'd1);
  endtask

  // Completion and next acceptance in the same cycle, with dr looped back to dx.
  task automatic t_back_to_back();
    int t;
    loop_en = 1'b1;
    @(negedge clk);
    div = 8'd2; word_len = 6'd8; tx_word = 32'hA5; start_valid = 1'b1;
    t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    chk("R10", "b2b first word", 64'(rx_word), 64'hA5);
    chk("R9", "b2b ready in done cycle", 64'(start_ready), 64'd1);
    tx_word = 32'h3C;
    @(negedge clk);
    chk("R9", "b2b reselected next cycle", 64'(cs_n), 64'd0);
    chk("R10", "b2b done dropped", 64'(done), 64'd0);
    start_valid = 1'b0;
    t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    chk("R6", "b2b second word", 64'(rx_word), 64'h3C);
    loop_en = 1'b0;
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    misses++;
    $display("FAIL watchdog run hung actual=%0d expected<%0d", cycles, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xfer("odd div5 len8",   5, 8,  32'h0000_00B6, 32'h0000_005D, 1'b0);
    t_xfer("even div4 len16", 4, 16, 32'h0000_C3A1, 32'h0000_1E7F, 1'b0);
    t_xfer("div0 R11 len4",   0, 4,  32'h0000_0009, 32'h0000_0006, 1'b0);
    t_xfer("div1 len32",      1, 32, 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b0);
    t_xfer("clamp low len2",  3, 2,  32'hFFFF_FFFA, 32'hFFFF_FFF5, 1'b0);
    t_xfer("clamp high len40", 2, 40, 32'h8001_4002, 32'h7F3E_10C5, 1'b0);
    t_xfer("busy poke len12", 6, 12, 32'h0000_0A5C, 32'h0000_0C33, 1'b1);
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule